// File: doc/BRIEF.md
# Hall Position Input Qualifier

This block watches the three Hall-effect position sensors of a brushless DC motor and produces a clean 3-bit rotor position word for the commutation and speed-capture logic. The raw sensor lines first pass through a two-stage synchronizer. They are then sampled on a slow sampling tick, whose rate is a selectable fraction of the system clock. A new position is accepted only when the same value has been seen on a programmed number of consecutive ticks. Each accepted change raises a one-cycle pulse, which the capture timer uses to clear or capture its count.

Power-stage switching puts noise on the sensor lines. Two measures filter it out. First, each rising edge of the PWM-active input starts a blanking window. The window lasts a programmed number of sampling ticks, and no samples are taken inside it. Second, a mode setting can limit sampling to the times when PWM is active, or to the times when a low-side switch conducts.

Control is a three-state machine. ST_OFF means detection is disabled. ST_RUN means sampling is allowed. ST_BLANK means the blanking window is running. Its transitions are:
- ST_OFF to ST_RUN when enabled.
- ST_RUN to ST_BLANK on a PWM rising edge when the delay is non-zero.
- ST_BLANK back to ST_RUN when the delay's final tick has elapsed, or at once if the delay is set to zero.
- ST_BLANK restarts its count on a further PWM rising edge.
- Any state goes to ST_OFF when the enable is cleared.

Top module: `hall_qualifier`

## Requirements
- R1: After reset, pos_out is 3'b000 and pos_chg is 0. Sensor inputs reach the sampler through two synchronizing flops.
- R2: smp_clk_sel sets the sampling tick period in system clocks: 00 gives 4, 01 gives 8, 10 gives 32, 11 gives 128. When det_en rises, the divider restarts from zero, so the first sample falls exactly one tick period later.
- R3: A position is accepted only after it has been sampled on match_cnt consecutive ticks. A sample that differs from the candidate restarts the run at one. A glitch shorter than the run never reaches pos_out.
- R4: match_cnt values 0 and 1 both accept a position on its first sample.
- R5: When smp_mode is 00, samples are taken only while pwm_on is 1.
- R6: When smp_mode is 01, samples are taken on every tick. When smp_mode is 10, samples are taken only while low_conduct is 1.
- R7: smp_mode 11 is reserved and takes no samples, so pos_out holds and no pulse occurs.
- R8: A rising edge of pwm_on suppresses sampling for blank_dly sampling ticks. A blank_dly of 0 means no suppression.
- R9: While det_en is 0, pos_out holds its last value and pos_chg stays 0.
- R10: Every change of pos_out coincides with exactly one pos_chg pulse, and each pulse lasts one system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hall_in | input | 3 | Raw Hall sensor lines |
| pwm_on | input | 1 | High while PWM output is active |
| low_conduct | input | 1 | High while a low-side switch conducts |
| det_en | input | 1 | Detection enable |
| smp_clk_sel | input | 2 | Sampling tick rate select |
| smp_mode | input | 2 | Sampling gate mode |
| match_cnt | input | 4 | Required consecutive matches |
| blank_dly | input | 7 | Blanking length in sampling ticks |
| pos_out | output | 3 | Qualified position word |
| pos_chg | output | 1 | One-cycle pulse on each position change |

## Verification
The hardest case to observe from the ports is the exact length of the match run. The free-running sampling tick has an unknown phase relative to any stimulus, so a check made from outside cannot tell whether a value was accepted after N samples or after N+1. The stimulus removes this uncertainty by turning det_en off and on again. This restarts the divider, so the k-th sample falls on a known clock edge. The bench then checks just before and just after the edge where the run of match_cnt samples completes. The blanking window is reached by raising pwm_on and changing the sensors in the same cycle, and the bench confirms that the value is accepted only after the programmed number of ticks.

// File: rtl/hq_pkg.sv
package hq_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_BLANK = 2'd2
    } hq_state_e;

    localparam logic [1:0] MODE_PWM  = 2'b00;
    localparam logic [1:0] MODE_FREE = 2'b01;
    localparam logic [1:0] MODE_LOW  = 2'b10;
    localparam logic [1:0] MODE_NONE = 2'b11;

    // sampling tick period in system clocks
    function automatic logic [7:0] tick_period(input logic [1:0] sel);
        case (sel)
            2'b00:   tick_period = 8'd4;
            2'b01:   tick_period = 8'd8;
            2'b10:   tick_period = 8'd32;
            default: tick_period = 8'd128;
        endcase
    endfunction

endpackage

// File: rtl/hq_sync.sv
module hq_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hq_tick.sv
module hq_tick #(
    parameter int DIV_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);
    import hq_pkg::*;

    logic [DIV_W-1:0] cnt;
    logic [7:0]       last;

    assign last = tick_period(sel) - 8'd1;
    assign tick = run && (8'(cnt) >= last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (!run)    cnt <= '0;
        else if (tick)    cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/hq_ctrl_fsm.sv
module hq_ctrl_fsm #(
    parameter int DLY_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             det_en,
    input  logic             tick,
    input  logic             pwm_on,
    input  logic             low_conduct,
    input  logic [1:0]       smp_mode,
    input  logic [DLY_W-1:0] blank_dly,
    output logic             sample_en,
    output logic             active
);
    import hq_pkg::*;

    hq_state_e        state, state_nx;
    logic [DLY_W-1:0] bcnt, bcnt_nx;
    logic             pwm_q;
    logic             pwm_rise;
    logic             gate;
    logic             start_blank;

    assign pwm_rise    = pwm_on && !pwm_q;
    assign start_blank = pwm_rise && (blank_dly != '0);

    always_comb begin
        unique case (smp_mode)
            MODE_PWM:  gate = pwm_on;
            MODE_FREE: gate = 1'b1;
            MODE_LOW:  gate = low_conduct;
            MODE_NONE: gate = 1'b0;
        endcase
    end

    // next state
    always_comb begin
        state_nx = state;
        bcnt_nx  = bcnt;
        unique case (state)
            ST_OFF: begin
                bcnt_nx = '0;
                if (det_en) state_nx = ST_RUN;
            end
            ST_RUN: begin
                bcnt_nx = '0;
                if (!det_en)          state_nx = ST_OFF;
                else if (start_blank) state_nx = ST_BLANK;
            end
            ST_BLANK: begin
                if (!det_en) begin
                    state_nx = ST_OFF;
                end else if (pwm_rise) begin
                    bcnt_nx = '0;
                end else if (blank_dly == '0) begin
                    state_nx = ST_RUN;
                end else if (tick) begin
                    if (bcnt == blank_dly - DLY_W'(1)) state_nx = ST_RUN;
                    else                               bcnt_nx = bcnt + 1'b1;
                end
            end
            default: state_nx = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            bcnt  <= '0;
            pwm_q <= 1'b0;
        end else begin
            state <= state_nx;
            bcnt  <= bcnt_nx;
            pwm_q <= pwm_on;
        end
    end

    // outputs
    always_comb begin
        sample_en = 1'b0;
        active    = 1'b0;
        unique case (state)
            ST_OFF:   ;
            ST_RUN: begin
                active    = det_en;
                sample_en = det_en && tick && gate && !start_blank;
            end
            ST_BLANK: active = det_en;
            default:  ;
        endcase
    end
endmodule

// File: rtl/hq_match.sv
module hq_match #(
    parameter int POS_W = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             sample_en,
    input  logic [POS_W-1:0] hall_s,
    input  logic [CNT_W-1:0] match_cnt,
    output logic [POS_W-1:0] pos_out,
    output logic             pos_chg
);
    logic [POS_W-1:0] cand;
    logic [CNT_W-1:0] hits, hits_nx, need;
    logic             same, accept;

    assign need    = (match_cnt == '0) ? CNT_W'(1) : match_cnt;
    assign same    = (hall_s == cand) && (hits != '0);
    assign hits_nx = !same ? CNT_W'(1) : ((hits >= need) ? hits : hits + 1'b1);
    assign accept  = sample_en && (hits_nx >= need) && (hall_s != pos_out);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand    <= '0;
            hits    <= '0;
            pos_out <= '0;
            pos_chg <= 1'b0;
        end else begin
            pos_chg <= accept;
            if (!active) begin
                hits <= '0;
            end else if (sample_en) begin
                cand <= hall_s;
                hits <= hits_nx;
                if (accept) pos_out <= hall_s;
            end
        end
    end
endmodule

// File: rtl/hall_qualifier.sv
module hall_qualifier #(
    parameter int POS_W  = 3,
    parameter int CNT_W  = 4,
    parameter int DLY_W  = 7,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] hall_in,
    input  logic             pwm_on,
    input  logic             low_conduct,
    input  logic             det_en,
    input  logic [1:0]       smp_clk_sel,
    input  logic [1:0]       smp_mode,
    input  logic [CNT_W-1:0] match_cnt,
    input  logic [DLY_W-1:0] blank_dly,
    output logic [POS_W-1:0] pos_out,
    output logic             pos_chg
);
    localparam int DIV_W = 7;

    logic [POS_W-1:0] hall_s;
    logic             tick, sample_en, active;

    hq_sync #(.W(POS_W), .STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(hall_in), .q(hall_s)
    );

    hq_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(det_en), .sel(smp_clk_sel), .tick(tick)
    );

    hq_ctrl_fsm #(.DLY_W(DLY_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .det_en(det_en), .tick(tick),
        .pwm_on(pwm_on), .low_conduct(low_conduct), .smp_mode(smp_mode),
        .blank_dly(blank_dly), .sample_en(sample_en), .active(active)
    );

    hq_match #(.POS_W(POS_W), .CNT_W(CNT_W)) u_match (
        .clk(clk), .rst_n(rst_n), .active(active), .sample_en(sample_en),
        .hall_s(hall_s), .match_cnt(match_cnt),
        .pos_out(pos_out), .pos_chg(pos_chg)
    );
endmodule

// File: rtl/hall_qualifier_chk.sv
module hall_qualifier_chk #(
    parameter int POS_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             det_en,
    input logic             pwm_on,
    input logic [1:0]       smp_mode,
    input logic [POS_W-1:0] pos_out,
    input logic             pos_chg
);
    a_r10_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        pos_chg |=> !pos_chg);

    a_r10_pulse_means_change: assert property (@(posedge clk) disable iff (!rst_n)
        pos_chg |-> (pos_out != $past(pos_out)));

    a_r10_change_has_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_out != $past(pos_out)) |-> pos_chg);

    a_r9_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(det_en) |-> ($stable(pos_out) && !pos_chg));

    a_r7_reserved_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(smp_mode) == 2'b11) |-> $stable(pos_out));

    a_r5_pwm_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(smp_mode) == 2'b00) && !$past(pwm_on)) |-> $stable(pos_out));
endmodule

bind hall_qualifier hall_qualifier_chk #(.POS_W(POS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .det_en(det_en), .pwm_on(pwm_on),
    .smp_mode(smp_mode), .pos_out(pos_out), .pos_chg(pos_chg)
);

// File: tb/hall_qualifier_test.sv
`timescale 1ns/1ps
module hall_qualifier_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall_in = 3'b000;
    logic       pwm_on = 1'b0, low_conduct = 1'b0, det_en = 1'b0;
    logic [1:0] smp_clk_sel = 2'b00, smp_mode = 2'b01;
    logic [3:0] match_cnt = 4'd1;
    logic [6:0] blank_dly = 7'd0;
    logic [2:0] pos_out;
    logic       pos_chg;

    int vectors = 0, miscompares = 0, pulses = 0, exp_pulses = 0, cycles = 0;
    logic [2:0] exp_pos = 3'b000;

    always #2.5 clk = ~clk;

    hall_qualifier uut (
        .clk(clk), .rst_n(rst_n), .hall_in(hall_in), .pwm_on(pwm_on),
        .low_conduct(low_conduct), .det_en(det_en), .smp_clk_sel(smp_clk_sel),
        .smp_mode(smp_mode), .match_cnt(match_cnt), .blank_dly(blank_dly),
        .pos_out(pos_out), .pos_chg(pos_chg)
    );

    always @(posedge clk) if (rst_n && pos_chg) pulses++;

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_pos(input string req, input logic [2:0] exp);
        vectors++;
        if (pos_out !== exp) begin
            miscompares++;
            $display("FAIL %s pos_out actual=%b expected=%b", req, pos_out, exp);
        end
    endtask

    task automatic chk_pulses(input string req);
        vectors++;
        if (pulses != exp_pulses) begin
            miscompares++;
            $display("FAIL %s pulses actual=%0d expected=%0d", req, pulses, exp_pulses);
        end
    endtask

    // restart the divider: the k-th sample then lands on edge k*period
    task automatic restart(input logic [2:0] v);
        det_en = 1'b0;
        wait_n(4);
        hall_in = v;
        wait_n(4);
        det_en = 1'b1;
    endtask

    task automatic t_reset;
        wait_n(1);
        chk_pos("R1 reset", 3'b000);
        vectors++;
        if (pos_chg !== 1'b0) begin
            miscompares++;
            $display("FAIL R1 pos_chg actual=%b expected=0", pos_chg);
        end
        rst_n = 1'b1;
        wait_n(2);
    endtask

    task automatic t_divider(input logic [1:0] sel, input int per, input logic [2:0] v);
        smp_clk_sel = sel; match_cnt = 4'd1; smp_mode = 2'b01;
        restart(v);
        wait_n(per - 2);
        chk_pos("R2 before first tick", exp_pos);
        wait_n(5);
        exp_pos = v; exp_pulses++;
        chk_pos("R2 after first tick", exp_pos);
        chk_pulses("R10 one pulse per change");
    endtask

    task automatic t_need(input logic [3:0] n, input int eff, input logic [2:0] v, input string req);
        smp_clk_sel = 2'b00; match_cnt = n; smp_mode = 2'b01;
        restart(v);
        wait_n(4*eff - 2);
        chk_pos(req, exp_pos);
        wait_n(5);
        exp_pos = v; exp_pulses++;
        chk_pos(req, exp_pos);
        chk_pulses("R10 pulse count");
    endtask

    task automatic t_glitch(input logic [2:0] v);
        smp_clk_sel = 2'b00; match_cnt = 4'd5; smp_mode = 2'b01;
        hall_in = v;
        wait_n(8);
        hall_in = exp_pos;
        wait_n(40);
        chk_pos("R3 short glitch rejected", exp_pos);
        chk_pulses("R3 no pulse for glitch");
        hall_in = v;
        wait_n(12);
        chk_pos("R3 run incomplete", exp_pos);
        wait_n(28);
        exp_pos = v; exp_pulses++;
        chk_pos("R3 run complete", exp_pos);
    endtask

    task automatic t_pwm_mode(input logic [2:0] v);
        smp_clk_sel = 2'b00; match_cnt = 4'd1; blank_dly = 7'd0;
        smp_mode = 2'b00; pwm_on = 1'b0;
        hall_in = v;
        wait_n(60);
        chk_pos("R5 no sample without pwm", exp_pos);
        pwm_on = 1'b1;
        wait_n(20);
        exp_pos = v; exp_pulses++;
        chk_pos("R5 sample while pwm on", exp_pos);
        pwm_on = 1'b0;
        wait_n(2);
    endtask

    task automatic t_low_mode(input logic [2:0] v);
        smp_clk_sel = 2'b00; match_cnt = 4'd1;
        smp_mode = 2'b10; low_conduct = 1'b0;
        hall_in = v;
        wait_n(60);
        chk_pos("R6 no sample without low side", exp_pos);
        low_conduct = 1'b1;
        wait_n(20);
        exp_pos = v; exp_pulses++;
        chk_pos("R6 sample while low side on", exp_pos);
        low_conduct = 1'b0;
    endtask

    task automatic t_reserved(input logic [2:0] v);
        smp_clk_sel = 2'b00; match_cnt = 4'd1; smp_mode = 2'b11;
        pwm_on = 1'b1; low_conduct = 1'b1;
        hall_in = v;
        wait_n(100);
        chk_pos("R7 reserved mode holds", exp_pos);
        chk_pulses("R7 no pulse");
        pwm_on = 1'b0; low_conduct = 1'b0;
        smp_mode = 2'b01;
        wait_n(20);
        exp_pos = v; exp_pulses++;
        chk_pos("R6 regular mode samples", exp_pos);
    endtask

    task automatic t_blank(input logic [2:0] v);
        smp_clk_sel = 2'b00; match_cnt = 4'd1; smp_mode = 2'b01;
        blank_dly = 7'd10; pwm_on = 1'b0;
        wait_n(2);
        pwm_on = 1'b1;
        hall_in = v;
        wait_n(30);
        chk_pos("R8 blanked after pwm rise", exp_pos);
        wait_n(30);
        exp_pos = v; exp_pulses++;
        chk_pos("R8 sampled after blanking", exp_pos);
        pwm_on = 1'b0; blank_dly = 7'd0;
    endtask

    task automatic t_disabled(input logic [2:0] v);
        smp_mode = 2'b01; match_cnt = 4'd1;
        det_en = 1'b0;
        wait_n(2);
        hall_in = v;
        wait_n(300);
        chk_pos("R9 hold while disabled", exp_pos);
        chk_pulses("R9 no pulse while disabled");
        det_en = 1'b1;
        wait_n(20);
        exp_pos = v; exp_pulses++;
        chk_pos("R9 resumes after enable", exp_pos);
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        miscompares++;
        $display("FAIL watchdog expired actual=%0d cycles expected<150000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        t_reset();
        t_divider(2'b00, 4,   3'b001);
        t_divider(2'b01, 8,   3'b011);
        t_divider(2'b10, 32,  3'b010);
        t_divider(2'b11, 128, 3'b110);
        t_need(4'd0,  1,  3'b100, "R4 count zero single sample");
        t_need(4'd1,  1,  3'b101, "R4 count one single sample");
        t_need(4'd3,  3,  3'b001, "R3 three matches");
        t_need(4'd15, 15, 3'b011, "R3 fifteen matches");
        t_glitch(3'b010);
        t_pwm_mode(3'b110);
        t_low_mode(3'b100);
        t_reserved(3'b101);
        t_blank(3'b001);
        t_disabled(3'b011);
        wait_n(4);
        chk_pulses("R10 total pulses");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule